// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit performs the architectural side of taking a trap. When the core raises a one-cycle trap strobe together with an interrupt flag, a cause code, the pc of the trapping instruction, its current privilege level and a candidate faulting address, the unit decides whether the trap is handled at machine or at supervisor level. It then records the event in that level's state and produces the pc of the handler.

The decision uses two delegation masks: one for interrupts and one for synchronous exceptions. The chosen level gets three things: its enable and previous-enable fields are stacked, the old privilege is saved, and its cause, exception-pc and trap-value registers are loaded. The handler address comes from the level's vector register, either direct or vectored by cause. The new privilege is held on an output.

A simple register port lets software write and read the vector, delegation, status and trap registers. A trap always wins over a software write to a register the trap updates.

Top module: `trap_entry_unit`

## Requirements
- R1: An interrupt (trap_irq=1) consults only the interrupt delegation mask (select 10). A synchronous exception consults only the exception delegation mask (select 9). Bit n of the consulted mask refers to cause n.
- R2: Privilege encoding is user=0, supervisor=1, machine=3. A trap goes to supervisor when priv_in is 0 or 1 and the consulted mask bit for the final cause is set; otherwise it goes to machine. From the clock edge that samples the strobe, priv_out shows the target level. priv_out resets to 3.
- R3: The target's trap value register receives trap_addr for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For every other synchronous cause, and for every interrupt, it receives 0.
- R4: A synchronous cause 8 is rewritten by priv_in: it becomes 8 from user, 9 from supervisor and 11 from machine. The rewritten cause is the one used for delegation and recording.
- R5: The status register (select 0) has s_ie at bit 0, m_ie at bit 1, s_pie at bit 2, m_pie at bit 3, s_pp at bit 4 and m_pp at bits 6:5. On entry to a level, its pie takes its ie, its pp takes the old privilege (supervisor keeps priv_in bit 0), and its ie is cleared. The other level's fields are kept.
- R6: The target's cause register holds the final cause in its low bits, with bit 31 set for interrupts and clear for exceptions. Machine cause is at select 3 and supervisor cause at select 7.
- R7: One cycle after the strobe, redir_vld pulses for one cycle and redir_pc holds the target's vector with bits 1:0 cleared. If the trap is an interrupt and vector bits 1:0 equal 1, 4 times the cause is added. Machine vector is at select 1 and supervisor vector at select 5.
- R8: The target's exception pc register receives trap_pc. Machine epc is at select 2 and supervisor epc at select 6. Machine tval is at select 4 and supervisor tval at select 8.
- R9: After reset, all registers read 0, priv_out is 3 and redir_vld is 0. Unused selects read 0.
- R10: In a strobe cycle, a software write to the status register or to the target level's epc, cause or tval is dropped. Software writes to other registers in that cycle take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_stb | input | 1 | One-cycle trap request |
| trap_irq | input | 1 | 1 for interrupt, 0 for exception |
| trap_code | input | 5 | Raw cause code |
| trap_pc | input | 32 | Pc of the trapping instruction |
| trap_addr | input | 32 | Faulting address candidate |
| priv_in | input | 2 | Current privilege level |
| sw_we | input | 1 | Software register write enable |
| sw_sel | input | 4 | Software write select |
| sw_wdata | input | 32 | Software write data |
| rd_sel | input | 4 | Read select |
| rd_data | output | 32 | Read data (combinational) |
| priv_out | output | 2 | Privilege after the latest trap |
| redir_vld | output | 1 | Handler redirect pulse |
| redir_pc | output | 32 | Handler address |

## Verification
A table of traps runs against a vectored machine vector and a direct supervisor vector. The table mixes user, supervisor and machine privilege, delegated and non-delegated causes, interrupts and exceptions. The environment-call and address-carrying causes in it separate delegation by privilege from delegation by mask. Matching cause numbers under both masks show that the wrong mask is not consulted. Interrupts with an address present separate tval gating. Directed sequences then chain three traps to follow the status stacking, and collide software writes with a strobe to show priority.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = 5;
    localparam int SEL_W  = 4;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_R = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 4'd0,
        SEL_M_VEC   = 4'd1,
        SEL_M_EPC   = 4'd2,
        SEL_M_CAUSE = 4'd3,
        SEL_M_TVAL  = 4'd4,
        SEL_S_VEC   = 4'd5,
        SEL_S_EPC   = 4'd6,
        SEL_S_CAUSE = 4'd7,
        SEL_S_TVAL  = 4'd8,
        SEL_EDELEG  = 4'd9,
        SEL_IDELEG  = 4'd10
    } sel_e;

    typedef struct packed {
        logic [1:0] m_pp;
        logic       s_pp;
        logic       m_pie;
        logic       s_pie;
        logic       m_ie;
        logic       s_ie;
    } status_t;

    localparam int STATUS_W = $bits(status_t);

    typedef struct packed {
        logic              to_s;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   tval;
    } route_t;

    localparam logic [CODE_W-1:0] CODE_ENV_U = 5'd8;
    localparam logic [CODE_W-1:0] CODE_ENV_S = 5'd9;
    localparam logic [CODE_W-1:0] CODE_ENV_M = 5'd11;

    function automatic logic [CODE_W-1:0] fix_env_call(input logic [CODE_W-1:0] c,
                                                        input priv_e p);
        logic [CODE_W-1:0] r;
        r = c;
        if (c == CODE_ENV_U) begin
            case (p)
                PRIV_S:  r = CODE_ENV_S;
                PRIV_M:  r = CODE_ENV_M;
                default: r = CODE_ENV_U;
            endcase
        end
        return r;
    endfunction

    function automatic logic has_address(input logic [CODE_W-1:0] c);
        case (c)
            5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W
) (
    input  logic          irq,
    input  logic [CW-1:0] code,
    input  priv_e         priv,
    input  logic [W-1:0]  addr,
    input  logic [W-1:0]  edeleg,
    input  logic [W-1:0]  ideleg,
    output route_t        route
);
    logic [CW-1:0] final_code;
    logic [W-1:0]  mask;

    always_comb begin
        final_code  = irq ? code : fix_env_call(code, priv);
        mask        = irq ? ideleg : edeleg;
        route.code  = final_code;
        route.to_s  = (priv == PRIV_U || priv == PRIV_S) && mask[final_code];
        route.tval  = (!irq && has_address(final_code)) ? addr : '0;
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W
) (
    input  logic [W-1:0]  tvec,
    input  logic          irq,
    input  logic [CW-1:0] code,
    output logic [W-1:0]  pc
);
    localparam logic [1:0] MODE_VECTORED = 2'd1;

    logic [W-1:0] base;
    logic [W-1:0] offs;

    always_comb begin
        base = {tvec[W-1:2], 2'b00};
        offs = (irq && tvec[1:0] == MODE_VECTORED) ? (W'(code) << 2) : '0;
        pc   = base + offs;
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trap_stb,
    input  logic          trap_irq,
    input  logic [CW-1:0] trap_code,
    input  logic [W-1:0]  trap_pc,
    input  logic [W-1:0]  trap_addr,
    input  logic [1:0]    priv_in,
    input  logic          sw_we,
    input  logic [SW-1:0] sw_sel,
    input  logic [W-1:0]  sw_wdata,
    input  logic [SW-1:0] rd_sel,
    output logic [W-1:0]  rd_data,
    output logic [1:0]    priv_out,
    output logic          redir_vld,
    output logic [W-1:0]  redir_pc
);
    localparam int PAD_W = W - 1 - CW;

    status_t      st;
    logic [W-1:0] m_vec, m_epc, m_cause, m_tval;
    logic [W-1:0] s_vec, s_epc, s_cause, s_tval;
    logic [W-1:0] edeleg, ideleg;
    priv_e        priv_q;
    logic         redir_vld_q;
    logic [W-1:0] redir_pc_q;

    route_t       route;
    logic [W-1:0] sel_vec;
    logic [W-1:0] vec_pc;
    logic [W-1:0] cause_word;
    priv_e        cur_priv;

    assign cur_priv = priv_e'(priv_in);

    trap_route #(.W(W), .CW(CW)) u_route (
        .irq    (trap_irq),
        .code   (trap_code),
        .priv   (cur_priv),
        .addr   (trap_addr),
        .edeleg (edeleg),
        .ideleg (ideleg),
        .route  (route)
    );

    assign sel_vec    = route.to_s ? s_vec : m_vec;
    assign cause_word = {trap_irq, {PAD_W{1'b0}}, route.code};

    trap_vector #(.W(W), .CW(CW)) u_vec (
        .tvec (sel_vec),
        .irq  (trap_irq),
        .code (route.code),
        .pc   (vec_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= '0;
            m_vec       <= '0;
            m_epc       <= '0;
            m_cause     <= '0;
            m_tval      <= '0;
            s_vec       <= '0;
            s_epc       <= '0;
            s_cause     <= '0;
            s_tval      <= '0;
            edeleg      <= '0;
            ideleg      <= '0;
            priv_q      <= PRIV_M;
            redir_vld_q <= 1'b0;
            redir_pc_q  <= '0;
        end else begin
            redir_vld_q <= trap_stb;
            if (trap_stb) redir_pc_q <= vec_pc;

            if (sw_we) begin
                case (sel_e'(sw_sel))
                    SEL_STATUS:  if (!trap_stb) st <= status_t'(sw_wdata[STATUS_W-1:0]);
                    SEL_M_VEC:   m_vec   <= sw_wdata;
                    SEL_M_EPC:   m_epc   <= sw_wdata;
                    SEL_M_CAUSE: m_cause <= sw_wdata;
                    SEL_M_TVAL:  m_tval  <= sw_wdata;
                    SEL_S_VEC:   s_vec   <= sw_wdata;
                    SEL_S_EPC:   s_epc   <= sw_wdata;
                    SEL_S_CAUSE: s_cause <= sw_wdata;
                    SEL_S_TVAL:  s_tval  <= sw_wdata;
                    SEL_EDELEG:  edeleg  <= sw_wdata;
                    SEL_IDELEG:  ideleg  <= sw_wdata;
                    default: ;
                endcase
            end

            if (trap_stb) begin
                if (route.to_s) begin
                    s_epc    <= trap_pc;
                    s_cause  <= cause_word;
                    s_tval   <= route.tval;
                    st.s_pie <= st.s_ie;
                    st.s_pp  <= priv_in[0];
                    st.s_ie  <= 1'b0;
                    priv_q   <= PRIV_S;
                end else begin
                    m_epc    <= trap_pc;
                    m_cause  <= cause_word;
                    m_tval   <= route.tval;
                    st.m_pie <= st.m_ie;
                    st.m_pp  <= priv_in;
                    st.m_ie  <= 1'b0;
                    priv_q   <= PRIV_M;
                end
            end
        end
    end

    always_comb begin
        case (sel_e'(rd_sel))
            SEL_STATUS:  rd_data = W'(st);
            SEL_M_VEC:   rd_data = m_vec;
            SEL_M_EPC:   rd_data = m_epc;
            SEL_M_CAUSE: rd_data = m_cause;
            SEL_M_TVAL:  rd_data = m_tval;
            SEL_S_VEC:   rd_data = s_vec;
            SEL_S_EPC:   rd_data = s_epc;
            SEL_S_CAUSE: rd_data = s_cause;
            SEL_S_TVAL:  rd_data = s_tval;
            SEL_EDELEG:  rd_data = edeleg;
            SEL_IDELEG:  rd_data = ideleg;
            default:     rd_data = '0;
        endcase
    end

    assign priv_out  = priv_q;
    assign redir_vld = redir_vld_q;
    assign redir_pc  = redir_pc_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W
) (
    input logic          clk,
    input logic          rst,
    input logic          trap_stb,
    input logic          trap_irq,
    input logic [CW-1:0] trap_code,
    input logic [1:0]    priv_in,
    input logic [1:0]    priv_out,
    input logic          redir_vld,
    input logic [W-1:0]  redir_pc,
    input status_t       st,
    input logic [W-1:0]  m_cause,
    input logic [W-1:0]  s_cause
);
    p_machine_stays_r2: assert property (@(posedge clk) disable iff (rst)
        (trap_stb && priv_in == 2'd3) |=> (priv_out == 2'd3));

    p_env_call_machine_r4: assert property (@(posedge clk) disable iff (rst)
        (trap_stb && !trap_irq && trap_code == 5'd8 && priv_in == 2'd3) |=> (m_cause == 32'd11));

    p_ie_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        trap_stb |=> (priv_out == 2'd3 ? !st.m_ie : !st.s_ie));

    p_irq_msb_r6: assert property (@(posedge clk) disable iff (rst)
        (trap_stb && trap_irq) |=> (priv_out == 2'd3 ? m_cause[W-1] : s_cause[W-1]));

    p_redirect_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        trap_stb |=> (redir_vld && redir_pc[1:0] == 2'b00));

    p_no_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        !trap_stb |=> !redir_vld);
endmodule

bind trap_entry_unit trap_entry_chk #(.W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trap_stb  (trap_stb),
    .trap_irq  (trap_irq),
    .trap_code (trap_code),
    .priv_in   (priv_in),
    .priv_out  (priv_out),
    .redir_vld (redir_vld),
    .redir_pc  (redir_pc),
    .st        (st),
    .m_cause   (m_cause),
    .s_cause   (s_cause)
);

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic        irq;
        logic [4:0]  code;
        logic [1:0]  priv;
        logic [31:0] pc;
        logic [31:0] addr;
        logic [1:0]  tgt;
        logic [31:0] cause;
        logic [31:0] tval;
        logic [31:0] npc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd2,  2'd0, 32'h100, 32'hDEAD, 2'd1, 32'd2,  32'h0,        32'h2000},
        '{1'b0, 5'd13, 2'd1, 32'h200, 32'hABCD0000, 2'd1, 32'd13, 32'hABCD0000, 32'h2000},
        '{1'b0, 5'd13, 2'd3, 32'h204, 32'h1234, 2'd3, 32'd13, 32'h1234,   32'h1000},
        '{1'b0, 5'd8,  2'd0, 32'h300, 32'h77,   2'd1, 32'd8,  32'h0,        32'h2000},
        '{1'b0, 5'd8,  2'd1, 32'h304, 32'h77,   2'd3, 32'd9,  32'h0,        32'h1000},
        '{1'b0, 5'd8,  2'd3, 32'h308, 32'h77,   2'd3, 32'd11, 32'h0,        32'h1000},
        '{1'b1, 5'd5,  2'd1, 32'h400, 32'h55,   2'd1, 32'h80000005, 32'h0,  32'h2000},
        '{1'b1, 5'd7,  2'd0, 32'h404, 32'h55,   2'd3, 32'h80000007, 32'h0,  32'h101C},
        '{1'b1, 5'd5,  2'd3, 32'h408, 32'h55,   2'd3, 32'h80000005, 32'h0,  32'h1014},
        '{1'b0, 5'd2,  2'd3, 32'h40C, 32'h55,   2'd3, 32'd2,  32'h0,        32'h1000},
        '{1'b1, 5'd2,  2'd1, 32'h500, 32'h66,   2'd3, 32'h80000002, 32'h0,  32'h1008},
        '{1'b0, 5'd5,  2'd1, 32'h504, 32'h9900, 2'd3, 32'd5,  32'h9900,   32'h1000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_stb = 1'b0;
    logic        trap_irq = 1'b0;
    logic [4:0]  trap_code = '0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_addr = '0;
    logic [1:0]  priv_in = '0;
    logic        sw_we = 1'b0;
    logic [3:0]  sw_sel = '0;
    logic [31:0] sw_wdata = '0;
    logic [3:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [1:0]  priv_out;
    logic        redir_vld;
    logic [31:0] redir_pc;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    trap_entry_unit u0 (
        .clk(clk), .rst(rst), .trap_stb(trap_stb), .trap_irq(trap_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .trap_addr(trap_addr),
        .priv_in(priv_in), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data), .priv_out(priv_out),
        .redir_vld(redir_vld), .redir_pc(redir_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    // Strobe one trap; returns at the negedge after the sampling posedge.
    task automatic fire(input logic irq, input logic [4:0] code, input logic [1:0] pr,
                        input logic [31:0] pc, input logic [31:0] addr);
        @(negedge clk);
        trap_stb = 1'b1; trap_irq = irq; trap_code = code;
        priv_in = pr; trap_pc = pc; trap_addr = addr;
        @(negedge clk);
        trap_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk("R9 priv_out", {30'b0, priv_out}, 32'd3);
        chk("R9 redir_vld", {31'b0, redir_vld}, 32'd0);
        for (int s = 0; s < 16; s++) begin
            rd(4'(s), v);
            chk("R9 reg zero", v, 32'd0);
        end

        // Configuration: vectored machine vector, direct supervisor vector
        wr(4'd1, 32'h0000_1001);
        wr(4'd5, 32'h0000_2000);
        wr(4'd9, (32'd1 << 2) | (32'd1 << 8) | (32'd1 << 13));
        wr(4'd10, (32'd1 << 5));

        // Table of traps: R1 R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            fire(VECS[i].irq, VECS[i].code, VECS[i].priv, VECS[i].pc, VECS[i].addr);
            chk("R2 target priv", {30'b0, priv_out}, {30'b0, VECS[i].tgt});
            chk("R7 redirect valid", {31'b0, redir_vld}, 32'd1);
            chk("R7 handler pc", redir_pc, VECS[i].npc);
            rd(VECS[i].tgt == 2'd1 ? 4'd7 : 4'd3, v);
            chk("R6 R4 R1 cause", v, VECS[i].cause);
            rd(VECS[i].tgt == 2'd1 ? 4'd8 : 4'd4, v);
            chk("R3 tval", v, VECS[i].tval);
            rd(VECS[i].tgt == 2'd1 ? 4'd6 : 4'd2, v);
            chk("R8 epc", v, VECS[i].pc);
            @(negedge clk);
            chk("R7 pulse ends", {31'b0, redir_vld}, 32'd0);
        end

        // R5 status stacking across three traps
        wr(4'd0, 32'h3);
        fire(1'b0, 5'd2, 2'd0, 32'h600, 32'h0);
        rd(4'd0, v);
        chk("R5 enter S from U", v, 32'h06);
        fire(1'b0, 5'd2, 2'd1, 32'h604, 32'h0);
        rd(4'd0, v);
        chk("R5 enter S from S", v, 32'h12);
        fire(1'b0, 5'd3, 2'd1, 32'h608, 32'h0);
        rd(4'd0, v);
        chk("R5 enter M from S", v, 32'h38);

        // R10 collision: trap target epc wins, unrelated vector write lands
        @(negedge clk);
        trap_stb = 1'b1; trap_irq = 1'b0; trap_code = 5'd3; priv_in = 2'd3;
        trap_pc = 32'h55; trap_addr = 32'h0;
        sw_we = 1'b1; sw_sel = 4'd2; sw_wdata = 32'h99;
        @(negedge clk);
        trap_stb = 1'b0; sw_we = 1'b0;
        rd(4'd2, v);
        chk("R10 epc trap wins", v, 32'h55);

        @(negedge clk);
        trap_stb = 1'b1; trap_irq = 1'b0; trap_code = 5'd3; priv_in = 2'd3;
        trap_pc = 32'h60;
        sw_we = 1'b1; sw_sel = 4'd5; sw_wdata = 32'h3000;
        @(negedge clk);
        trap_stb = 1'b0; sw_we = 1'b0;
        rd(4'd5, v);
        chk("R10 other write lands", v, 32'h3000);

        @(negedge clk);
        trap_stb = 1'b1; trap_irq = 1'b0; trap_code = 5'd3; priv_in = 2'd3;
        trap_pc = 32'h64;
        sw_we = 1'b1; sw_sel = 4'd0; sw_wdata = 32'h7F;
        @(negedge clk);
        trap_stb = 1'b0; sw_we = 1'b0;
        rd(4'd0, v);
        // prior 0x38 (m_pp=1,m_pie=1,s_pp=1); from M: m_pie=m_ie=0, m_pp=3
        chk("R10 status write dropped", v, 32'h70);

        rd(4'd15, v);
        chk("R9 unused select", v, 32'd0);

        finish_run();
    end
endmodule